// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table in memory. Pages are 8 KB. The upper 8 address bits select one of 256 directory slots, each covering 16 MB. The next 11 bits select one of 2048 slots in a table page. The low 13 bits pass through unchanged as the page offset. There is no middle level: a directory entry points straight at a table page, and a 4-byte entry size means one table fills exactly one page.

A requester offers a virtual address and a directory base address with a valid/ready handshake. The walker then reads at most two words through a request/response memory port. The first read fetches the directory entry and the second fetches the table entry. The walker then presents either a physical address or a fault, and holds the result until the requester takes it. Bit 0 of every entry is its present flag. The first page of the address space (0 to 8191) never translates, so that null pointers always trap. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0 and mem_req_valid is 0. req_ready is 1 only while no walk is in progress, and a walk starts on a cycle where req_valid and req_ready are both 1.
- R2: A virtual address whose bits 31:13 are all zero ends with res_fault = 1 and no memory read, and res_valid rises on the cycle after acceptance.
- R3: The first read of a walk is at address base + 4 × VA[31:24].
- R4: A directory entry whose bit 0 is 0 ends the walk with res_fault = 1 after exactly one read.
- R5: The second read is at address {PDE[31:13], VA[23:13], 2'b00}.
- R6: A table entry whose bit 0 is 0 ends the walk with res_fault = 1 after exactly two reads.
- R7: When both entries have bit 0 set, res_fault = 0 and res_pa = {PTE[31:13], VA[12:0]}.
- R8: A memory request stays asserted with a stable address until mem_req_ready accepts it. At most one read is outstanding, and the walker consumes mem_rsp_valid only after its request has been accepted.
- R9: res_valid, res_fault and res_pa stay stable until res_ready is 1. The walker is then idle again and ready for the next request on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Byte address of the page directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry word |
| res_valid | output | 1 | Translation result available |
| res_ready | input | 1 | Requester takes the result |
| res_fault | output | 1 | Translation failed |
| res_pa | output | 32 | Physical address on success |

## Verification
The bound checker watches the following on every cycle:
- idle readiness excludes memory traffic and pending results;
- a memory request holds its address while it waits for ready;
- a result holds while it waits for ready;
- an accepted null-page address faults on the next cycle;
- a successful result carries the accepted page offset.

The bench scenarios show the remaining behaviour: that the read addresses, the number of reads and the physical frame all agree with a model of the table contents. They cover missing directory entries, missing table entries, two directory bases, the edges of the null page, and random memory and requester stalls.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 13,
  parameter int DIR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [VA_W-1:0] req_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_fault,
  output logic [VA_W-1:0] res_pa
);
  localparam int TBL_W = VA_W - OFF_W - DIR_W;
  localparam int FRM_W = VA_W - OFF_W;

  typedef enum logic [1:0] {IDLE, READ_DIR, READ_PTE, DONE} state_t;

  state_t          state;
  logic [VA_W-1:0] va_q, base_q, ent_q;
  logic            issued, fault_q;

  logic [VA_W-1:0] dir_off, tbl_off, tbl_base;
  logic            walking, rsp_take, null_page;

  assign dir_off   = VA_W'(va_q[VA_W-1 -: DIR_W]) << 2;
  assign tbl_off   = VA_W'(va_q[OFF_W +: TBL_W]) << 2;
  assign tbl_base  = {ent_q[VA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign null_page = (req_va[VA_W-1:OFF_W] == '0);

  assign walking       = (state == READ_DIR) || (state == READ_PTE);
  assign rsp_take      = walking && issued && mem_rsp_valid;
  assign req_ready     = (state == IDLE);
  assign mem_req_valid = walking && !issued;
  assign mem_req_addr  = (state == READ_DIR) ? base_q + dir_off : tbl_base + tbl_off;
  assign res_valid     = (state == DONE);
  assign res_fault     = fault_q;
  assign res_pa        = {ent_q[VA_W-1:OFF_W], va_q[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      va_q    <= '0;
      base_q  <= '0;
      ent_q   <= '0;
      issued  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        IDLE: if (req_valid) begin
          va_q    <= req_va;
          base_q  <= req_base;
          ent_q   <= '0;
          issued  <= 1'b0;
          fault_q <= null_page;
          state   <= null_page ? DONE : READ_DIR;
        end
        READ_DIR, READ_PTE: begin
          if (mem_req_valid && mem_req_ready) issued <= 1'b1;
          if (rsp_take) begin
            ent_q  <= mem_rsp_data;
            issued <= 1'b0;
            if (!mem_rsp_data[0]) begin
              fault_q <= 1'b1;
              state   <= DONE;
            end else begin
              state <= (state == READ_DIR) ? READ_PTE : DONE;
            end
          end
        end
        DONE: if (res_ready) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  logic [FRM_W-1:0] unused_frame;
  assign unused_frame = ent_q[VA_W-1:OFF_W];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_fault,
  input logic [VA_W-1:0] res_pa
);
  logic [VA_W-1:0] va_cap;
  always_ff @(posedge clk)
    if (!rst_n) va_cap <= '0;
    else if (req_valid && req_ready) va_cap <= req_va;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  p_null_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_va[VA_W-1:OFF_W] == '0) |=> (res_valid && res_fault));

  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_pa[OFF_W-1:0] == va_cap[OFF_W-1:0]));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .res_valid(res_valid), .res_ready(res_ready),
  .res_fault(res_fault), .res_pa(res_pa));

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic [31:0] res_pa;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  logic [31:0] rd_addr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (.*);

  function automatic logic [31:0] rd_model(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] h;
    if (a[31:10] == b[31:10]) begin
      logic [7:0] idx = a[9:2];
      return {6'b0, 1'b1, 4'b0, idx, 12'b0, (idx[1:0] != 2'b11)};
    end
    h = a * 32'h9E3779B1;
    return {h[31:1], ~(a[3] & a[5])};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
        pend = 0;
        mem_req_ready = 1'b0;
      end else if (pend) begin
        mem_req_ready = 1'b0;
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_model(paddr, req_base);
          pend = 0;
        end else dly--;
      end else begin
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          pend  = 1;
          paddr = mem_req_addr;
          dly   = $urandom % 3;
          if (reads < 2) rd_addr[reads] = mem_req_addr;
          reads++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base);
    logic [31:0] pde, pte, a0, a1, exp_pa, pa0;
    bit exp_fault, f0;
    int exp_reads, hold;
    a0 = base + {22'b0, va[31:24], 2'b00};
    pde = rd_model(a0, base);
    a1 = {pde[31:13], va[23:13], 2'b00};
    pte = rd_model(a1, base);
    exp_pa = {pte[31:13], va[12:0]};
    if (va[31:13] == 0) begin exp_fault = 1; exp_reads = 0; end
    else if (!pde[0])   begin exp_fault = 1; exp_reads = 1; end
    else if (!pte[0])   begin exp_fault = 1; exp_reads = 2; end
    else                begin exp_fault = 0; exp_reads = 2; end

    @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_va = va; req_base = base;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_va = $urandom; 
    while (!res_valid) @(negedge clk);
    f0 = res_fault; pa0 = res_pa;
    if (exp_reads == 0) check(f0 == 1'b1, "R2", "null page fault", {31'b0, f0}, 32'h1);
    else if (exp_reads == 1) check(f0 == 1'b1, "R4", "dir not present fault", {31'b0, f0}, 32'h1);
    else if (exp_fault) check(f0 == 1'b1, "R6", "pte not present fault", {31'b0, f0}, 32'h1);
    else begin
      check(f0 == 1'b0, "R7", "success flag", {31'b0, f0}, 32'h0);
      check(pa0 == exp_pa, "R7", "physical address", pa0, exp_pa);
    end
    check(reads == exp_reads, exp_reads == 0 ? "R2" : (exp_reads == 1 ? "R4" : "R6"),
          "read count", reads, exp_reads);
    if (exp_reads >= 1) check(rd_addr[0] == a0, "R3", "directory address", rd_addr[0], a0);
    if (exp_reads == 2) check(rd_addr[1] == a1, "R5", "table address", rd_addr[1], a1);
    hold = $urandom % 4;
    repeat (hold) @(negedge clk);
    check(res_valid && res_fault == f0 && (f0 || res_pa == pa0), "R9", "result held",
          res_pa, pa0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(req_ready && !res_valid, "R9", "idle after take", {31'b0, req_ready}, 32'h1);
    check(reads == exp_reads, "R8", "no extra reads", reads, exp_reads);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset req_ready", {31'b0, req_ready}, 32'h1);
    check(res_valid == 1'b0, "R1", "reset res_valid", {31'b0, res_valid}, 32'h0);
    check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    walk(32'h0000_0000, 32'h0010_0000);
    walk(32'h0000_1FFF, 32'h0010_0000);
    walk(32'h0000_2000, 32'h0010_0000);
    walk(32'h0300_0000, 32'h0010_0000);
    walk(32'hD004_000C, 32'h0010_0000);
    walk(32'hFFFF_FFFF, 32'h0010_0000);
    walk(32'hD004_000C, 32'h0030_0000);
    walk(32'h0000_0000, 32'h0030_0000);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va = $urandom;
      if (($urandom % 10) == 0) va[31:13] = '0;
      walk(va, ($urandom % 2) ? 32'h0010_0000 : 32'h0030_0000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule